// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. Four wires drive it: a test clock, a mode select, a serial data input and an active-low asynchronous reset. On each rising test-clock edge the mode select steers a sixteen-state controller. The controller moves between an instruction path and a data path, and each path has capture, shift and update phases. A 4-bit instruction register chooses which data register sits between the serial input and the serial output. The block holds a 32-bit identification register and a one-stage bypass register. A third choice routes the serial return of an external boundary-scan chain to the output.

The block drives external test registers through decoded state strobes: capture, shift and update for both paths, plus test-logic-reset. It also brings out the active instruction code and flags for the sample and external-test instructions. Every test follows the same order. An instruction scan loads an opcode, which takes effect on the falling edge in the instruction update state. A data scan then captures, shifts and updates the selected register. The serial output changes only on falling edges, and an enable output marks when it is valid.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is in test-logic-reset (`tlr`=1), `ir_code` is 0010 (identification), `tdo_en` is 0 and `tdo` is 0.
- R2: Five consecutive rising edges of `tck` with `tms`=1 bring the controller to test-logic-reset from any state, and the next falling edge restores `ir_code` to 0010.
- R3: Each of `tlr`, `cap_dr`, `sh_dr`, `upd_dr`, `cap_ir`, `sh_ir`, `upd_ir` is high exactly while the controller is in the matching state, and at most one of them is high at a time.
- R4: Capture-IR loads the pattern 0001 into the instruction shift stage, and the following IR shift presents it on `tdo` least significant bit first (1, 0, 0, 0).
- R5: During Shift-IR, `tdi` enters the most significant bit and the stage shifts toward the least significant bit. `ir_code` takes the shifted value on the falling edge in Update-IR and does not change in any other state apart from test-logic-reset.
- R6: Under opcode 0010, Capture-DR loads the 32-bit identification value, whose least significant bit is 1. Shift-DR then presents that value on `tdo` least significant bit first.
- R7: Under opcode 1111, Capture-DR loads 0 into the single bypass stage, so the data shifted out is a 0 followed by `tdi` delayed by one stage.
- R8: Any opcode other than 0000, 0001 and 0010 (for example 0101 or 1010) selects the bypass stage with the behaviour of R7.
- R9: Opcode 0001 (sample/preload) raises `is_sample`, and opcode 0000 (external test) raises `is_extest`. Under either one, Shift-DR presents `chain_so` on `tdo`.
- R10: `tdo` and `tdo_en` change only on falling edges of `tck`. `tdo_en` is 1 exactly in the half cycles that follow a falling edge taken in Shift-DR or Shift-IR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data input |
| chain_so | input | 1 | Serial return of the external boundary chain |
| tdo | output | 1 | Serial data output, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| tlr | output | 1 | Test-logic-reset state strobe |
| cap_dr | output | 1 | Capture-DR state strobe |
| sh_dr | output | 1 | Shift-DR state strobe |
| upd_dr | output | 1 | Update-DR state strobe |
| cap_ir | output | 1 | Capture-IR state strobe |
| sh_ir | output | 1 | Shift-IR state strobe |
| upd_ir | output | 1 | Update-IR state strobe |
| ir_code | output | IR_W | Active instruction code |
| is_extest | output | 1 | Active instruction is external test |
| is_sample | output | 1 | Active instruction is sample/preload |

## Verification
A wrong controller state shows up on the strobes at the rising edge that causes it. It appears one falling edge later as a missing or misplaced `tdo_en`, so an error in the state walk becomes visible within one clock. A corrupted instruction latch changes the register routed to `tdo`. An identification read then returns a 0 followed by delayed input bits instead of the fixed value, and this shows in the first shifted bit. A shift stage that is off by one position shows as the pattern displaced by one bit across the 8-bit and 32-bit scans.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

   typedef enum logic [3:0] {
      ST_RESET   = 4'd0,
      ST_IDLE    = 4'd1,
      ST_SEL_DR  = 4'd2,
      ST_CAP_DR  = 4'd3,
      ST_SH_DR   = 4'd4,
      ST_EX1_DR  = 4'd5,
      ST_PAU_DR  = 4'd6,
      ST_EX2_DR  = 4'd7,
      ST_UPD_DR  = 4'd8,
      ST_SEL_IR  = 4'd9,
      ST_CAP_IR  = 4'd10,
      ST_SH_IR   = 4'd11,
      ST_EX1_IR  = 4'd12,
      ST_PAU_IR  = 4'd13,
      ST_EX2_IR  = 4'd14,
      ST_UPD_IR  = 4'd15
   } port_state_e;

   typedef enum logic [1:0] {
      PATH_BYP   = 2'd0,
      PATH_ID    = 2'd1,
      PATH_CHAIN = 2'd2
   } dr_path_e;

   // Successor state for one rising test-clock edge.
   function automatic port_state_e step_state(input port_state_e cur, input logic mode);
      port_state_e nxt;
      unique case (cur)
         ST_RESET:  nxt = mode ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = mode ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = mode ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = mode ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = mode ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = mode ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = mode ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = mode ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = mode ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = mode ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = mode ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = mode ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = mode ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = mode ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = mode ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = mode ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
   import scan_port_pkg::*;
(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   output logic st_reset,
   output logic st_cap_dr,
   output logic st_sh_dr,
   output logic st_upd_dr,
   output logic st_cap_ir,
   output logic st_sh_ir,
   output logic st_upd_ir
);

   port_state_e state_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state_q <= ST_RESET;
      else         state_q <= step_state(state_q, tms);
   end

   always_comb begin
      st_reset  = (state_q == ST_RESET);
      st_cap_dr = (state_q == ST_CAP_DR);
      st_sh_dr  = (state_q == ST_SH_DR);
      st_upd_dr = (state_q == ST_UPD_DR);
      st_cap_ir = (state_q == ST_CAP_IR);
      st_sh_ir  = (state_q == ST_SH_IR);
      st_upd_ir = (state_q == ST_UPD_IR);
   end

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir #(
   parameter int          IR_W       = 4,
   parameter logic [IR_W-1:0] CAPTURE_PAT = 4'b0001,
   parameter logic [IR_W-1:0] RESET_OP    = 4'b0010
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  logic            in_reset,
   input  logic            do_capture,
   input  logic            do_shift,
   input  logic            do_update,
   output logic [IR_W-1:0] code,
   output logic            serial_out
);

   logic [IR_W-1:0] stage_q;
   logic [IR_W-1:0] latch_q;

   // Shift stage: captures the fixed pattern, then moves toward bit 0.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         stage_q <= CAPTURE_PAT;
      else if (do_capture) stage_q <= CAPTURE_PAT;
      else if (do_shift)   stage_q <= {tdi, stage_q[IR_W-1:1]};
   end

   // Parallel latch: moves on the falling edge so the new code is stable
   // for the whole next rising edge.
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)        latch_q <= RESET_OP;
      else if (in_reset)  latch_q <= RESET_OP;
      else if (do_update) latch_q <= stage_q;
   end

   assign code       = latch_q;
   assign serial_out = stage_q[0];

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr #(
   parameter int              ID_W     = 32,
   parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5E_3C4B,
   parameter bit              HAS_ID   = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tdi,
   input  logic do_capture,
   input  logic do_shift,
   input  logic pick_id,
   input  logic pick_byp,
   output logic id_out,
   output logic byp_out
);

   logic byp_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                     byp_q <= 1'b0;
      else if (do_capture && pick_byp) byp_q <= 1'b0;
      else if (do_shift && pick_byp)   byp_q <= tdi;
   end
   assign byp_out = byp_q;

   generate
      if (HAS_ID) begin : g_id
         logic [ID_W-1:0] id_q;
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                    id_q <= ID_VALUE;
            else if (do_capture && pick_id) id_q <= ID_VALUE;
            else if (do_shift && pick_id)   id_q <= {tdi, id_q[ID_W-1:1]};
         end
         assign id_out = id_q[0];
      end else begin : g_no_id
         assign id_out = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
   import scan_port_pkg::*;
#(
   parameter int                IR_W        = 4,
   parameter int                ID_W        = 32,
   parameter logic [ID_W-1:0]   ID_VALUE    = 32'h1A5E_3C4B,
   parameter bit                HAS_ID      = 1'b1,
   parameter logic [IR_W-1:0]   IR_CAPTURE  = 4'b0001,
   parameter logic [IR_W-1:0]   OP_EXTEST   = 4'b0000,
   parameter logic [IR_W-1:0]   OP_SAMPLE   = 4'b0001,
   parameter logic [IR_W-1:0]   OP_IDCODE   = 4'b0010,
   parameter logic [IR_W-1:0]   OP_BYPASS   = 4'b1111
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   input  logic            chain_so,
   output logic            tdo,
   output logic            tdo_en,
   output logic            tlr,
   output logic            cap_dr,
   output logic            sh_dr,
   output logic            upd_dr,
   output logic            cap_ir,
   output logic            sh_ir,
   output logic            upd_ir,
   output logic [IR_W-1:0] ir_code,
   output logic            is_extest,
   output logic            is_sample
);

   localparam logic [IR_W-1:0] ALL_ONES = {IR_W{1'b1}};

   // Elaboration-time parameter checks.
   generate
      if (IR_W < 2) begin : g_bad_irw
         $error("scan_port_ctrl: IR_W must be at least 2");
      end
      if (ID_W < 2) begin : g_bad_idw
         $error("scan_port_ctrl: ID_W must be at least 2");
      end
      if (IR_CAPTURE[1:0] != 2'b01) begin : g_bad_cap
         $error("scan_port_ctrl: IR_CAPTURE must end in 01");
      end
      if (HAS_ID && (ID_VALUE[0] != 1'b1)) begin : g_bad_id
         $error("scan_port_ctrl: identification value must have bit 0 set");
      end
      if (OP_BYPASS != ALL_ONES) begin : g_bad_byp
         $error("scan_port_ctrl: bypass opcode must be all ones");
      end
      if ((OP_IDCODE == OP_BYPASS) || (OP_IDCODE == OP_SAMPLE) ||
          (OP_IDCODE == OP_EXTEST) || (OP_SAMPLE == OP_EXTEST) ||
          (OP_SAMPLE == OP_BYPASS) || (OP_EXTEST == OP_BYPASS)) begin : g_bad_ops
         $error("scan_port_ctrl: opcodes must be distinct");
      end
   endgenerate

   scan_port_fsm u_fsm (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .st_reset  (tlr),
      .st_cap_dr (cap_dr),
      .st_sh_dr  (sh_dr),
      .st_upd_dr (upd_dr),
      .st_cap_ir (cap_ir),
      .st_sh_ir  (sh_ir),
      .st_upd_ir (upd_ir)
   );

   logic ir_so;

   scan_port_ir #(
      .IR_W        (IR_W),
      .CAPTURE_PAT (IR_CAPTURE),
      .RESET_OP    (OP_IDCODE)
   ) u_ir (
      .tck        (tck),
      .trst_n     (trst_n),
      .tdi        (tdi),
      .in_reset   (tlr),
      .do_capture (cap_ir),
      .do_shift   (sh_ir),
      .do_update  (upd_ir),
      .code       (ir_code),
      .serial_out (ir_so)
   );

   // Instruction decode: unassigned codes fall through to bypass.
   dr_path_e path;
   always_comb begin
      path = PATH_BYP;
      if (HAS_ID && (ir_code == OP_IDCODE))                  path = PATH_ID;
      else if ((ir_code == OP_SAMPLE) || (ir_code == OP_EXTEST)) path = PATH_CHAIN;
   end

   assign is_extest = (ir_code == OP_EXTEST);
   assign is_sample = (ir_code == OP_SAMPLE);

   logic id_so;
   logic byp_so;

   scan_port_dr #(
      .ID_W     (ID_W),
      .ID_VALUE (ID_VALUE),
      .HAS_ID   (HAS_ID)
   ) u_dr (
      .tck        (tck),
      .trst_n     (trst_n),
      .tdi        (tdi),
      .do_capture (cap_dr),
      .do_shift   (sh_dr),
      .pick_id    (path == PATH_ID),
      .pick_byp   (path == PATH_BYP),
      .id_out     (id_so),
      .byp_out    (byp_so)
   );

   logic dr_so;
   always_comb begin
      unique case (path)
         PATH_ID:    dr_so = id_so;
         PATH_CHAIN: dr_so = chain_so;
         default:    dr_so = byp_so;
      endcase
   end

   // Output stage on the falling edge.
   logic tdo_q;
   logic en_q;
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         en_q <= sh_dr | sh_ir;
         if (sh_ir)      tdo_q <= ir_so;
         else if (sh_dr) tdo_q <= dr_so;
         else            tdo_q <= 1'b0;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_en = en_q;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk #(
   parameter int              IR_W      = 4,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'b0010
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tms,
   input logic            tdo,
   input logic            tdo_en,
   input logic            tlr,
   input logic            cap_dr,
   input logic            sh_dr,
   input logic            upd_dr,
   input logic            cap_ir,
   input logic            sh_ir,
   input logic            upd_ir,
   input logic [IR_W-1:0] ir_code
);

   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)     hi_run <= 3'd0;
      else if (!tms)   hi_run <= 3'd0;
      else if (hi_run != 3'd7) hi_run <= hi_run + 3'd1;
   end

   // R2: five high mode samples land in test-logic-reset
   p_five_high_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run >= 3'd5) |-> tlr);

   // R3: state strobes are mutually exclusive
   p_strobes_onehot_r3: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}));

   // R1: a held reset state keeps the identification opcode
   p_reset_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (tlr && $past(tlr)) |-> (ir_code == OP_IDCODE));

   // R5: instruction only moves in update or reset states
   p_ir_stable_r5: assert property (@(posedge tck) disable iff (!trst_n)
      !(upd_ir || tlr) |-> $stable(ir_code));

   // R10: output enable follows the shift states across the falling edge
   p_enable_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en == (sh_dr || sh_ir));

   // R10: output is low while not enabled
   p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_en |-> !tdo);

endmodule

bind scan_port_ctrl scan_port_chk #(
   .IR_W      (IR_W),
   .OP_IDCODE (OP_IDCODE)
) u_chk (
   .tck     (tck),
   .trst_n  (trst_n),
   .tms     (tms),
   .tdo     (tdo),
   .tdo_en  (tdo_en),
   .tlr     (tlr),
   .cap_dr  (cap_dr),
   .sh_dr   (sh_dr),
   .upd_dr  (upd_dr),
   .cap_ir  (cap_ir),
   .sh_ir   (sh_ir),
   .upd_ir  (upd_ir),
   .ir_code (ir_code)
);

// File: tb/sim_scan_port_ctrl.sv
module sim_scan_port_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] ID_VAL = 32'h1A5E_3C4B;

   typedef struct packed {
      logic [3:0]  op;
      logic [5:0]  nbits;
      logic [31:0] din;
      logic [31:0] dout;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{op: 4'b0010, nbits: 6'd32, din: 32'h0000_0000, dout: ID_VAL},        // R6
      '{op: 4'b1111, nbits: 6'd8,  din: 32'h0000_00B4, dout: 32'h0000_0068}, // R7
      '{op: 4'b0101, nbits: 6'd8,  din: 32'h0000_005A, dout: 32'h0000_00B4}, // R8
      '{op: 4'b1010, nbits: 6'd8,  din: 32'h0000_00C3, dout: 32'h0000_0086}, // R8
      '{op: 4'b1111, nbits: 6'd1,  din: 32'h0000_0001, dout: 32'h0000_0000}, // R7
      '{op: 4'b0010, nbits: 6'd32, din: 32'hFFFF_FFFF, dout: ID_VAL}         // R6
   };

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic chain_so = 1'b0;
   logic tdo, tdo_en, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
   logic is_extest, is_sample;
   logic [3:0] ir_code;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) tck = ~tck;

   scan_port_ctrl u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .chain_so(chain_so),
      .tdo(tdo), .tdo_en(tdo_en), .tlr(tlr), .cap_dr(cap_dr), .sh_dr(sh_dr),
      .upd_dr(upd_dr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
      .ir_code(ir_code), .is_extest(is_extest), .is_sample(is_sample)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic shift(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         step(i == n - 1, din[i]);
      end
   endtask

   task automatic ir_scan(input logic [3:0] op, output logic [31:0] cap);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      shift(4, {28'd0, op}, cap);
      step(1, 0); step(0, 0);
   endtask

   task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
      step(1, 0); step(0, 0); step(0, 0);
      shift(n, din, dout);
      step(1, 0); step(0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge tck);
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] got;
      logic [31:0] cap;

      repeat (3) @(negedge tck);
      #1;
      // R1: held reset
      check("R1 reset tlr", {31'd0, tlr}, 32'd1);
      check("R1 reset ir_code", {28'd0, ir_code}, 32'h2);
      check("R1 reset tdo_en/tdo", {30'd0, tdo_en, tdo}, 32'd0);
      trst_n = 1'b1;
      step(0, 0);
      // R10: idle gives no output enable
      check("R10 idle tdo_en", {31'd0, tdo_en}, 32'd0);

      // R6: identification read straight after reset
      dr_scan(32, 32'h0, got);
      check("R6 id after reset", got, ID_VAL);
      check("R6 id lsb one", {31'd0, got[0]}, 32'd1);

      // Table walk: instruction scan then data scan
      foreach (VECS[k]) begin
         ir_scan(VECS[k].op, cap);
         check("R4 ir capture pattern", cap, 32'h1);
         check("R5 ir_code after update", {28'd0, ir_code}, {28'd0, VECS[k].op});
         dr_scan(int'(VECS[k].nbits), VECS[k].din, got);
         check("R6 R7 R8 data scan", got, VECS[k].dout);
      end

      // R3 and R5: strobes along an instruction scan, code held until update
      step(1, 0); step(1, 0); step(0, 0);
      check("R3 capture-ir strobe", {25'd0, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}, 32'b0000100);
      step(0, 0);
      check("R3 shift-ir strobe", {25'd0, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}, 32'b0000010);
      check("R10 shift-ir enable", {31'd0, tdo_en}, 32'd1);
      shift(4, 32'h1, got);   // sample/preload
      check("R5 code held before update", {28'd0, ir_code}, 32'h2);
      step(1, 0);
      check("R3 update-ir strobe", {25'd0, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}, 32'b0000001);
      check("R5 code after update", {28'd0, ir_code}, 32'h1);
      step(0, 0);
      check("R9 sample flags", {30'd0, is_sample, is_extest}, 32'b10);

      // R9: chain return routed; R10: change on falling edge only
      step(1, 0); step(0, 0);
      check("R3 capture-dr strobe", {25'd0, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}, 32'b0100000);
      chain_so = 1'b1;
      step(0, 0);
      check("R9 chain bit0", {31'd0, tdo}, 32'd1);
      for (int i = 1; i < 6; i++) begin
         chain_so = i[0];
         step(0, 0);
         check("R9 chain routed", {31'd0, tdo}, {31'd0, i[0]});
      end
      chain_so = 1'b1;   // tdo now 1, enter last step and look between edges
      @(posedge tck); #1;
      check("R10 tdo stable after rise", {31'd0, tdo}, 32'd1);
      chain_so = 1'b0;
      @(negedge tck); #1;
      check("R10 tdo moves on fall", {31'd0, tdo}, 32'd0);
      step(1, 0);
      check("R10 exit disables", {30'd0, tdo_en, tdo}, 32'd0);
      step(1, 0);
      check("R3 update-dr strobe", {25'd0, tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir}, 32'b0001000);
      step(0, 0);

      // R9: external test flag
      ir_scan(4'b0000, cap);
      check("R9 extest flags", {30'd0, is_sample, is_extest}, 32'b01);

      // R2: five high steps from Shift-DR restore reset and identification
      ir_scan(4'b1111, cap);
      step(1, 0); step(0, 0); step(0, 0);
      for (int i = 0; i < 4; i++) step(1, 0);
      check("R2 not yet reset after four", {31'd0, tlr}, 32'd0);
      step(1, 0);
      check("R2 reset after five", {31'd0, tlr}, 32'd1);
      check("R2 id restored", {28'd0, ir_code}, 32'h2);

      // R1: asynchronous reset while a bypass instruction is active
      step(0, 0);
      ir_scan(4'b1111, cap);
      check("R1 bypass loaded", {28'd0, ir_code}, 32'hF);
      #2 trst_n = 1'b0;
      #1;
      check("R1 async tlr", {31'd0, tlr}, 32'd1);
      check("R1 async ir_code", {28'd0, ir_code}, 32'h2);
      @(negedge tck); #1;
      trst_n = 1'b1;
      step(0, 0);
      dr_scan(32, 32'h0, got);
      check("R1 R6 id after async reset", got, ID_VAL);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule